// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block is the host side of a 16-bit successive-approximation converter with a serial output. On a start request it raises the convert line for a short, fixed pulse. It then waits for the converter's busy line to drop. After that it drives sixteen shift clocks, divided down from the system clock, and collects the serial data into a parallel word. The word is presented with a one-cycle valid strobe. The first data bit is already present on the data line when the conversion ends, so it is taken before any shift clock is issued. Each later bit is sampled on a falling shift-clock edge, because the converter updates the line on rising edges.

The block also puts the converter into its deep-sleep state and brings it back out. To enter sleep it runs two conversions with no shift-clock edge between them, and the converter powers down when busy falls after the second one. To leave sleep it sends one rising shift-clock edge and then waits a programmable settle time before it accepts a new conversion. If busy does not fall within a timeout, an error flag is raised and the block returns to idle without reading.

Top module: `sar_host_seq`

## Requirements
- R1: Under reset, and in the cycle after reset is asserted, `adc_cnv`, `adc_sck`, `result_vld` and `tmo_err` are all 0.
- R2: A `start_req` sampled while idle drives `adc_cnv` high for exactly CNV_CYC system cycles. After that, `adc_cnv` stays low for as long as `adc_busy` is high.
- R3: `adc_sck` stays low while `adc_busy` is high. After busy falls, a read produces exactly 16 rising `adc_sck` edges. Each high phase and each low phase of `adc_sck` lasts SCK_HALF system cycles.
- R4: The result word is assembled most significant bit first. Bit 15 is taken from `adc_sdo` when busy is seen low. Bits 14 down to 0 are taken at the falling `adc_sck` edges that follow rising edges 1 to 15. `result_vld` is high for exactly one cycle per read.
- R5: A `start_req` that arrives during a conversion or a read is ignored. It starts no further conversion.
- R6: If `adc_busy` is still high BUSY_TMO cycles after the convert pulse ends, `tmo_err` goes to 1. No shift clock is issued and the block returns to idle. `tmo_err` clears at the next accepted request.
- R7: A `sleep_req` sampled while idle causes two convert pulses, each one waiting for busy to fall. No `adc_sck` edge occurs between or after them, and no `result_vld` is produced.
- R8: While the converter is asleep, `start_req` is ignored and `adc_cnv` stays low.
- R9: A `wake_req` while asleep produces exactly one rising `adc_sck` edge. It is followed by WAKE_CYC cycles during which `start_req` is ignored. After that, the block is idle and accepts a start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request one conversion and read |
| sleep_req | input | 1 | Request entry to converter deep sleep |
| wake_req | input | 1 | Request exit from converter deep sleep |
| adc_busy | input | 1 | Converter busy indicator |
| adc_sdo | input | 1 | Converter serial data |
| adc_cnv | output | 1 | Convert-start line |
| adc_sck | output | 1 | Shift clock to the converter |
| result | output | DW | Last assembled conversion word |
| result_vld | output | 1 | One-cycle strobe: result updated |
| tmo_err | output | 1 | Busy timeout seen on last conversion |

## Verification
A wrong sequencer state shows at the converter pins within one shift-clock period. Examples are a read count that stops at 15 or goes on to 17, or a convert pulse during busy. It also shows in the assembled word at the strobe, where a one-bit skew changes every non-symmetric test pattern. A wrong sleep or wake path appears as an extra or a missing shift-clock edge, which changes whether a bench model of the converter believes it is asleep. It also appears as a conversion that starts, or fails to start, inside the wake settle window. All of these are visible within a few hundred cycles of the stimulus.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the converter host sequencer.
package sar_seq_pkg;
    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAITB,
        ST_SHIFT,
        ST_ASLEEP,
        ST_WKSCK,
        ST_WKWAIT
    } seq_st_t;

    // Purpose of the conversion in flight
    typedef enum logic [1:0] {
        CK_READ,
        CK_SLP1,
        CK_SLP2
    } conv_kind_t;
endpackage

// File: rtl/sar_sck_gen.sv
`timescale 1ns/1ps
// Shift-clock divider. While en is high, sck toggles every HALF system
// cycles, starting low. fall_ev marks the cycle whose edge drives sck low.
// Assumes HALF >= 1. Dropping en forces sck low at the next edge.
module sar_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sck,
    output logic fall_ev
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick    = en && (cnt == CW'(HALF - 1));
    assign fall_ev = tick && sck;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_seq_timer.sv
`timescale 1ns/1ps
// Saturating cycle counter used for pulse widths, timeouts and settle
// waits. cnt is 0 in the first cycle after clr is seen.
module sar_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Count up, stop at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_sdo_deser.sv
`timescale 1ns/1ps
// Serial-to-parallel register, MSB first. load seeds the word with the
// bit already present on the data line; each shift appends one bit.
module sar_sdo_deser #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          sdo,
    output logic [DW-1:0] word
);
    // Seed or shift in one data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load) begin
            word <= {{(DW-1){1'b0}}, sdo};
        end else if (shift) begin
            word <= {word[DW-2:0], sdo};
        end
    end
endmodule

// File: rtl/sar_host_seq.sv
`timescale 1ns/1ps
// Host sequencer for a serial SAR converter.
// It pulses the convert line, waits for busy to fall (with a timeout), and
// then clocks in DW bits. It also runs the two-pulse sleep entry and the
// single-edge wake with its settle wait. Assumptions: busy rises while the
// convert pulse is still high; all timings are in system clock cycles.
module sar_host_seq
    import sar_seq_pkg::*;
#(
    parameter int DW       = 16,
    parameter int SCK_HALF = 2,
    parameter int CNV_CYC  = 4,
    parameter int BUSY_TMO = 500,
    parameter int WAKE_CYC = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          sleep_req,
    input  logic          wake_req,
    input  logic          adc_busy,
    input  logic          adc_sdo,
    output logic          adc_cnv,
    output logic          adc_sck,
    output logic [DW-1:0] result,
    output logic          result_vld,
    output logic          tmo_err
);
    localparam int TMAX = (BUSY_TMO > WAKE_CYC)
                          ? ((BUSY_TMO > CNV_CYC) ? BUSY_TMO : CNV_CYC)
                          : ((WAKE_CYC > CNV_CYC) ? WAKE_CYC : CNV_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int NW   = $clog2(DW);

    seq_st_t    state, st_nx;
    conv_kind_t kind;
    logic [TW-1:0] tmr;
    logic [NW-1:0] nfall;
    logic [DW-1:0] word;
    logic          fall_ev, sck_en, last_fall, tmo_hit, busy_done;

    assign adc_cnv   = (state == ST_CNV);
    assign sck_en    = (state == ST_SHIFT) || (state == ST_WKSCK);
    assign last_fall = fall_ev && (nfall == NW'(DW - 1));
    assign tmo_hit   = (tmr == TW'(BUSY_TMO - 1));
    assign busy_done = (state == ST_WAITB) && !adc_busy;

    sar_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk(clk), .rst_n(rst_n), .en(sck_en),
        .sck(adc_sck), .fall_ev(fall_ev)
    );

    sar_seq_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(st_nx != state), .cnt(tmr)
    );

    sar_sdo_deser #(.DW(DW)) u_des (
        .clk(clk), .rst_n(rst_n),
        .load(busy_done && (kind == CK_READ)),
        .shift((state == ST_SHIFT) && fall_ev && !last_fall),
        .sdo(adc_sdo), .word(word)
    );

    // Next-phase selection
    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE:   if (sleep_req || start_req) st_nx = ST_CNV;
            ST_CNV:    if (tmr == TW'(CNV_CYC - 1)) st_nx = ST_WAITB;
            ST_WAITB: begin
                if (!adc_busy) begin
                    unique case (kind)
                        CK_READ: st_nx = ST_SHIFT;
                        CK_SLP1: st_nx = ST_CNV;
                        default: st_nx = ST_ASLEEP;
                    endcase
                end else if (tmo_hit) begin
                    st_nx = ST_IDLE;
                end
            end
            ST_SHIFT:  if (last_fall) st_nx = ST_IDLE;
            ST_ASLEEP: if (wake_req) st_nx = ST_WKSCK;
            ST_WKSCK:  if (fall_ev) st_nx = ST_WKWAIT;
            ST_WKWAIT: if (tmr == TW'(WAKE_CYC - 1)) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // Phase, conversion kind, bit count, error flag and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= CK_READ;
            nfall      <= '0;
            tmo_err    <= 1'b0;
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            state      <= st_nx;
            result_vld <= 1'b0;
            if (state == ST_IDLE) begin
                if (sleep_req) begin
                    kind    <= CK_SLP1;
                    tmo_err <= 1'b0;
                end else if (start_req) begin
                    kind    <= CK_READ;
                    tmo_err <= 1'b0;
                end
            end
            if (busy_done && (kind == CK_SLP1)) kind <= CK_SLP2;
            if ((state == ST_WAITB) && adc_busy && tmo_hit) tmo_err <= 1'b1;
            if (state != ST_SHIFT) nfall <= '0;
            else if (fall_ev)      nfall <= nfall + 1'b1;
            if ((state == ST_SHIFT) && last_fall) begin
                result     <= word;
                result_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_host_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the host sequencer, attached by bind.
module sar_host_seq_chk
    import sar_seq_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    cnv,
    input logic    busy,
    input logic    sck,
    input logic    vld,
    input logic    err,
    input seq_st_t st
);
    // R2: no convert edge while the converter is busy
    p_cnv_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnv) |=> !cnv);
    // R3: shift clock held low during a conversion
    p_sck_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sck);
    // R4: result strobe lasts a single cycle
    p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    // R6: the error only rises after busy was seen stuck high
    p_tmo_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));
    // R8: pins quiet while the converter sleeps
    p_asleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ASLEEP) |-> (!cnv && !sck));
    // R9: no convert or clock during the wake settle wait
    p_wake_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WKWAIT) |-> (!cnv && !sck));
endmodule

bind sar_host_seq sar_host_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnv(adc_cnv), .busy(adc_busy),
    .sck(adc_sck), .vld(result_vld), .err(tmo_err), .st(state)
);

// File: tb/sim_sar_host_seq.sv
`timescale 1ns/1ps
module sim_sar_host_seq;
    localparam int DW = 16, SCK_HALF = 2, CNV_CYC = 4;
    localparam int BUSY_TMO = 100, WAKE_CYC = 50, CONV_CLK = 40;
    localparam int NV = 6;
    // stimulus word driven by the converter model / expected result word
    localparam logic [15:0] VEC_IN [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                            16'h8001, 16'h1234, 16'h7FFE};
    localparam logic [15:0] VEC_EXP[NV] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                            16'h8001, 16'h1234, 16'h7FFE};

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
    logic adc_busy = 1'b0, adc_sdo;
    logic adc_cnv, adc_sck, result_vld, tmo_err;
    logic [DW-1:0] result;

    int n_tests = 0, n_fail = 0;
    // converter model state
    logic [15:0] word = 16'h0;
    logic hang = 1'b0;
    int n_conv = 0, n_rise = 0, n_wake = 0, n_sleep = 0;
    int rise_at_end = 0, conv_at_sck = 0, abort_mark = 0;
    // monitors
    int cnv_run = 0, last_cnv_w = 0, sck_run = 0, bad_sck = 0, n_vld = 0;

    always #2 clk = ~clk;

    sar_host_seq #(.DW(DW), .SCK_HALF(SCK_HALF), .CNV_CYC(CNV_CYC),
                   .BUSY_TMO(BUSY_TMO), .WAKE_CYC(WAKE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .sleep_req(sleep_req), .wake_req(wake_req), .adc_busy(adc_busy),
        .adc_sdo(adc_sdo), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
        .result(result), .result_vld(result_vld), .tmo_err(tmo_err));

    // Converter model: serial data follows rising shift-clock edges
    always_comb begin
        int d;
        d = n_rise - rise_at_end;
        adc_sdo = (d > 15) ? word[0] : word[15 - d];
    end

    // Converter model: conversion timing and sleep entry
    always begin
        int base;
        @(posedge adc_cnv);
        #1 adc_busy = 1'b1;
        n_conv = n_conv + 1;
        repeat (CONV_CLK) @(posedge clk);
        if (hang) begin
            wait (!hang);
            abort_mark = n_conv;
        end
        #1;
        base = (conv_at_sck > abort_mark) ? conv_at_sck : abort_mark;
        if (n_conv - base >= 2 && n_sleep == n_wake) n_sleep = n_sleep + 1;
        rise_at_end = n_rise;
        adc_busy = 1'b0;
    end

    // Converter model: shift-clock edge wakes or shifts
    always @(posedge adc_sck) begin
        if (n_sleep != n_wake) n_wake = n_wake + 1;
        n_rise = n_rise + 1;
        conv_at_sck = n_conv;
    end

    // Pin monitors sampled away from the active edge
    always @(negedge clk) begin
        if (adc_cnv) cnv_run = cnv_run + 1;
        else if (cnv_run != 0) begin last_cnv_w = cnv_run; cnv_run = 0; end
        if (adc_sck) sck_run = sck_run + 1;
        else if (sck_run != 0) begin
            if (sck_run != SCK_HALF) bad_sck = bad_sck + 1;
            sck_run = 0;
        end
        if (adc_sck && adc_busy) bad_sck = bad_sck + 1;
        if (result_vld) n_vld = n_vld + 1;
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic wait_vld(output bit got, output logic [15:0] cap);
        got = 0; cap = '0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (result_vld) begin got = 1; cap = result; return; end
        end
    endtask

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit got;
        logic [15:0] cap;
        int c0, r0, v0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({adc_cnv, adc_sck, result_vld, tmo_err} == 4'b0, "R1 reset outputs",
            {adc_cnv, adc_sck, result_vld, tmo_err}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R2 pulse width, R3 edge count, R4 word
        for (int i = 0; i < NV; i++) begin
            word = VEC_IN[i];
            r0 = n_rise; v0 = n_vld;
            pulse(start_req);
            wait_vld(got, cap);
            repeat (6) @(negedge clk);
            chk(got && cap == VEC_EXP[i], "R4 result word", cap, VEC_EXP[i]);
            chk(n_rise - r0 == 16, "R3 rising sck count", n_rise - r0, 16);
            chk(last_cnv_w == CNV_CYC, "R2 cnv pulse width", last_cnv_w, CNV_CYC);
            chk(n_vld - v0 == 1, "R4 single strobe", n_vld - v0, 1);
        end
        chk(bad_sck == 0, "R3 sck phase width / sck during busy", bad_sck, 0);

        // R5: second start during conversion ignored
        word = 16'h3C5A; c0 = n_conv;
        pulse(start_req);
        repeat (3) @(negedge clk);
        pulse(start_req);
        wait_vld(got, cap);
        pulse(start_req);
        wait_vld(got, cap);
        repeat (10) @(negedge clk);
        chk(n_conv - c0 == 2, "R5 start during busy/shift ignored", n_conv - c0, 2);
        chk(cap == 16'h3C5A, "R5 word intact", cap, 16'h3C5A);

        // R6: busy timeout
        hang = 1'b1; r0 = n_rise; v0 = n_vld;
        pulse(start_req);
        repeat (CNV_CYC + BUSY_TMO - 10) @(negedge clk);
        chk(tmo_err == 1'b0, "R6 no early timeout", tmo_err, 0);
        repeat (20) @(negedge clk);
        chk(tmo_err == 1'b1, "R6 timeout flag", tmo_err, 1);
        chk(n_rise == r0 && n_vld == v0, "R6 no read after timeout", n_rise - r0, 0);
        hang = 1'b0;
        repeat (20) @(negedge clk);
        word = 16'h0F0F;
        pulse(start_req);
        chk(tmo_err == 1'b0, "R6 flag cleared by next start", tmo_err, 0);
        wait_vld(got, cap);
        chk(cap == 16'h0F0F, "R6 recovery read", cap, 16'h0F0F);
        repeat (10) @(negedge clk);

        // R7: sleep entry
        c0 = n_conv; r0 = n_rise; v0 = n_vld;
        pulse(sleep_req);
        repeat (200) @(negedge clk);
        chk(n_conv - c0 == 2, "R7 two convert pulses", n_conv - c0, 2);
        chk(n_rise == r0, "R7 no sck edge", n_rise - r0, 0);
        chk(n_vld == v0, "R7 no result strobe", n_vld - v0, 0);
        chk(n_sleep - n_wake == 1, "R7 converter asleep", n_sleep - n_wake, 1);

        // R8: start ignored while asleep
        c0 = n_conv;
        pulse(start_req);
        repeat (60) @(negedge clk);
        chk(n_conv == c0 && !adc_cnv, "R8 start ignored asleep", n_conv - c0, 0);

        // R9: wake with single edge and settle wait
        r0 = n_rise;
        pulse(wake_req);
        repeat (10) @(negedge clk);
        chk(n_rise - r0 == 1, "R9 single wake edge", n_rise - r0, 1);
        chk(n_sleep == n_wake, "R9 converter awake", n_sleep - n_wake, 0);
        pulse(start_req);
        repeat (10) @(negedge clk);
        chk(n_conv == c0, "R9 start ignored during settle", n_conv - c0, 0);
        repeat (WAKE_CYC) @(negedge clk);
        word = 16'hC001;
        pulse(start_req);
        wait_vld(got, cap);
        chk(got && cap == 16'hC001, "R9 read after wake", cap, 16'hC001);
        repeat (10) @(negedge clk);

        // R1: reset asserted mid-read
        pulse(start_req);
        wait (adc_sck);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk({adc_cnv, adc_sck, result_vld, tmo_err} == 4'b0, "R1 reset mid-read",
            {adc_cnv, adc_sck, result_vld, tmo_err}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule